// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block decides when a small 8-bit processor core stops its main program to serve an interrupt, and which handler it enters. It collects one external pin source (source 0) and a parameterised number of peripheral sources (sources 1 and up). Each source has a sticky pending flag and an enable bit. A single global enable gates every source. When a request is accepted, the block runs a fixed-length entry sequence. The entry pushes the 9-bit program counter and ends with a vector index for the fetch unit. A return strobe from the core starts a fixed-length return sequence that pops the program counter and re-arms the global enable.

The core supplies a strobe at each instruction boundary, a sleep indication, the return strobe, its current program counter, the popped stack word, and register writes for enables, flag clears and the global enable. The external pin is synchronised inside the block. Its sense mode selects low level, any change, falling edge or rising edge.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After synchronous reset all flags, all enables and the global enable read zero. No push, pop, restore or vector strobe is active.
- R2: A source event sets its flag on the next clock edge whatever the enable bits are. The flag stays set until hardware serves it or software clears it.
- R3: A flag-clear write clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged. An event in the same cycle wins over the clear.
- R4: A source is pending when its flag and its enable bit are both set. Among pending sources the lowest index is served first. Several pending sources are served one per entry sequence. `vec_idx` carries the source index in binary.
- R5: Accepting a request clears the global enable. No further entry starts until the global enable is set again by a register write or by a return.
- R6: The flag of the served source is cleared on the clock edge that ends the cycle in which `vec_valid` is high.
- R7: A request is accepted on a clock edge where the global enable is set, a source is pending, and `insn_done` or `sleeping` is high. `push_valid` is high with `push_pc` equal to the sampled `pc_in` in the first cycle after acceptance. `vec_valid` is high for one cycle in the 4th cycle after acceptance, or in the 8th cycle when `sleeping` was high at acceptance.
- R8: While awake, a pending request is not accepted on any edge where `insn_done` is low.
- R9: A `reti` strobe while the block is idle starts a 4-cycle return. `pop_req` is high in the first cycle and `pop_data` is sampled there. `pc_restore_valid` is high with that value in the 4th cycle. The global enable reads 1 after that cycle.
- R10: After a return, the first `insn_done` edge never starts an entry. Only a later boundary can.
- R11: With `sense_mode` 2'b01 (any change), 2'b10 (falling) or 2'b11 (rising), a matching transition on `ext_pin` sets flag 0 on the 3rd clock edge after the pin changes. This allows for two synchroniser stages. Non-matching transitions leave flag 0 clear.
- R12: With `sense_mode` 2'b00 (low level), flag 0 stays clear. Source 0 is pending only while the synchronised pin is low and enable bit 0 is set. Once the pin is back high, nothing of the request is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_evt | input | NUM_PERIPH (3) | Peripheral event pulses; bit k drives source k+1 |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| sense_mode | input | 2 | Pin sense: 00 low level, 01 any change, 10 falling, 11 rising |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | NUM_PERIPH+1 (4) | New enable bits, one per source |
| clr_we | input | 1 | Write strobe for write-one-to-clear of flags |
| clr_wdata | input | NUM_PERIPH+1 (4) | Ones mark flags to clear |
| gie_we | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | New global enable value |
| insn_done | input | 1 | Instruction boundary strobe |
| sleeping | input | 1 | Core is in sleep |
| reti | input | 1 | Return-from-interrupt strobe |
| pc_in | input | PC_W (9) | Current program counter |
| pop_data | input | PC_W (9) | Stack word returned for a pop |
| push_valid | output | 1 | Push the program counter this cycle |
| push_pc | output | PC_W (9) | Program counter to push |
| pop_req | output | 1 | Pop the stack this cycle |
| pc_restore_valid | output | 1 | Load the restored program counter |
| pc_restore | output | PC_W (9) | Restored program counter |
| vec_valid | output | 1 | One-cycle vector strobe at the end of entry |
| vec_idx | output | clog2(NUM_PERIPH+1) (2) | Source index being vectored |
| flags_o | output | NUM_PERIPH+1 (4) | Current flags |
| enables_o | output | NUM_PERIPH+1 (4) | Current enable bits |
| gie_o | output | 1 | Current global enable |

## Verification
The hardest state to reach is the one right after a return. There, the global enable is already set again and other sources are still pending, yet the first instruction boundary must pass without a new entry. The stimulus raises three peripheral flags with all enables on and serves the first one. It then issues the return strobe and a single boundary, checking that no push follows. A second boundary must start the next entry in priority order. Reaching the low-level pin case also takes care: the pin must pass the synchroniser while the global enable is still off, and then go high again before the global enable is set.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ENTRY,
        SQ_RETURN,
        SQ_HOLD
    } seq_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_edge_t;

endpackage

// File: rtl/ivc_pin_sense.sv
module ivc_pin_sense
    import ivc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pin,
    input  sense_e mode,
    output logic   edge_evt,
    output logic   level_req
);
    // sh_q[SYNC_STAGES-1] is the synchronised pin, sh_q[SYNC_STAGES] its previous value
    logic [SYNC_STAGES:0] sh_q;
    pin_edge_t            ed;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[SYNC_STAGES-1:0], pin};
    end

    always_comb begin
        ed.rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
        ed.fall = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];
        unique case (mode)
            SENSE_ANY:  edge_evt = ed.rise | ed.fall;
            SENSE_FALL: edge_evt = ed.fall;
            SENSE_RISE: edge_evt = ed.rise;
            default:    edge_evt = 1'b0;
        endcase
        level_req = (mode == SENSE_LOW) & ~sh_q[SYNC_STAGES-1];
    end

    // R12: a level request never coexists with an edge event
    a_r12_level_no_edge: assert property (@(posedge clk) disable iff (rst)
        level_req |-> !edge_evt);

endmodule

// File: rtl/ivc_flag_bank.sv
module ivc_flag_bank #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] hw_clr,
    input  logic [NSRC-1:0] noflag,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_wdata,
    input  logic            en_we,
    input  logic [NSRC-1:0] en_wdata,
    output logic [NSRC-1:0] flag_q,
    output logic [NSRC-1:0] en_q
);
    logic [NSRC-1:0] flag_d;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        logic sw_clr;
        assign sw_clr    = clr_we & clr_wdata[i];
        assign flag_d[i] = ~noflag[i] & (evt[i] | (flag_q[i] & ~sw_clr & ~hw_clr[i]));

        // R2: an event latches regardless of enables
        a_r2_event_latches: assert property (@(posedge clk) disable iff (rst)
            (evt[i] && !noflag[i]) |=> flag_q[i]);
        // R3: a zero in the clear data keeps the flag
        a_r3_zero_keeps: assert property (@(posedge clk) disable iff (rst)
            (clr_we && !clr_wdata[i] && flag_q[i] && !hw_clr[i] && !noflag[i]) |=> flag_q[i]);
        // R3: a one in the clear data drops the flag when no event competes
        a_r3_one_clears: assert property (@(posedge clk) disable iff (rst)
            (clr_we && clr_wdata[i] && !evt[i]) |=> !flag_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= flag_d;
            if (en_we) en_q <= en_wdata;
        end
    end

endmodule

// File: rtl/ivc_prio_pick.sv
module ivc_prio_pick #(
    parameter int NSRC  = 4,
    parameter int IDX_W = 2
) (
    input  logic [NSRC-1:0]  pend,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [NSRC-1:0] below_mask;

    always_comb begin
        any = |pend;
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end

    assign below_mask = (NSRC'(1) << idx) - NSRC'(1);

    // R4: the chosen source is pending and nothing of lower index is
    always_comb begin
        if (any) begin
            a_r4_lowest_wins: assert (pend[idx] && ((pend & below_mask) == '0));
        end
    end

endmodule

// File: rtl/ivc_sequencer.sv
module ivc_sequencer
    import ivc_pkg::*;
#(
    parameter int IDX_W     = 2,
    parameter int PC_W      = 9,
    parameter int ENTRY_CYC = 4,
    parameter int WAKE_CYC  = 4,
    parameter int RET_CYC   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_any,
    input  logic [IDX_W-1:0] win_idx,
    input  logic             gie_we,
    input  logic             gie_wdata,
    input  logic             insn_done,
    input  logic             sleeping,
    input  logic             reti,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [PC_W-1:0]  pop_data,
    output logic             gie_q,
    output logic             push_valid,
    output logic [PC_W-1:0]  push_pc,
    output logic             pop_req,
    output logic             pc_restore_valid,
    output logic [PC_W-1:0]  pc_restore,
    output logic             vec_valid,
    output logic [IDX_W-1:0] vec_idx
);
    localparam int CNT_W = $clog2(ENTRY_CYC + WAKE_CYC + RET_CYC + 1);

    seq_e             state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [PC_W-1:0]  pc_q;
    logic             first_q;
    logic             accept;
    logic             ret_last;

    assign accept   = (state_q == SQ_IDLE) && gie_q && req_any && (insn_done || sleeping);
    assign ret_last = (state_q == SQ_RETURN) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            pc_q    <= '0;
            first_q <= 1'b0;
            gie_q   <= 1'b0;
        end else begin
            first_q <= accept;
            if (accept)        gie_q <= 1'b0;
            else if (ret_last) gie_q <= 1'b1;
            else if (gie_we)   gie_q <= gie_wdata;

            unique case (state_q)
                SQ_IDLE: begin
                    if (accept) begin
                        state_q <= SQ_ENTRY;
                        cnt_q   <= sleeping ? CNT_W'(ENTRY_CYC + WAKE_CYC - 1)
                                            : CNT_W'(ENTRY_CYC - 1);
                        idx_q   <= win_idx;
                        pc_q    <= pc_in;
                    end else if (reti) begin
                        state_q <= SQ_RETURN;
                        cnt_q   <= CNT_W'(RET_CYC - 1);
                    end
                end
                SQ_ENTRY: begin
                    if (cnt_q == '0) state_q <= SQ_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                SQ_RETURN: begin
                    if (cnt_q == CNT_W'(RET_CYC - 1)) pc_q <= pop_data;
                    if (cnt_q == '0) state_q <= SQ_HOLD;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                SQ_HOLD: begin
                    if (insn_done) state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign push_valid       = (state_q == SQ_ENTRY) && first_q;
    assign push_pc          = pc_q;
    assign pop_req          = (state_q == SQ_RETURN) && (cnt_q == CNT_W'(RET_CYC - 1));
    assign pc_restore_valid = ret_last;
    assign pc_restore       = pc_q;
    assign vec_valid        = (state_q == SQ_ENTRY) && (cnt_q == '0);
    assign vec_idx          = idx_q;

    // Checker counter: cycles spent in the current entry
    logic [CNT_W-1:0] ent_run_q;
    always_ff @(posedge clk) begin
        if (rst || accept)              ent_run_q <= '0;
        else if (state_q == SQ_ENTRY)   ent_run_q <= ent_run_q + 1'b1;
    end

    // R5: acceptance drops the global enable
    a_r5_gie_drops: assert property (@(posedge clk) disable iff (rst)
        accept |=> !gie_q);
    // R7: vector strobe arrives after a fixed entry length
    a_r7_entry_len: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (ent_run_q == CNT_W'(ENTRY_CYC - 1) ||
                       ent_run_q == CNT_W'(ENTRY_CYC + WAKE_CYC - 1)));
    // R8: a push only follows a boundary or sleep
    a_r8_boundary: assert property (@(posedge clk) disable iff (rst)
        push_valid |-> $past(insn_done || sleeping));
    // R9: the return ends with the global enable set
    a_r9_gie_back: assert property (@(posedge clk) disable iff (rst)
        pc_restore_valid |=> gie_q);
    // R10: the first boundary after a return never starts an entry
    a_r10_hold_blocks: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_HOLD) |=> !push_valid);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int NUM_PERIPH  = 3,
    parameter int PC_W        = 9,
    parameter int ENTRY_CYC   = 4,
    parameter int WAKE_CYC    = 4,
    parameter int RET_CYC     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int NSRC       = NUM_PERIPH + 1,
    localparam int IDX_W      = $clog2(NSRC)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PERIPH-1:0] periph_evt,
    input  logic                  ext_pin,
    input  logic [1:0]            sense_mode,
    input  logic                  en_we,
    input  logic [NSRC-1:0]       en_wdata,
    input  logic                  clr_we,
    input  logic [NSRC-1:0]       clr_wdata,
    input  logic                  gie_we,
    input  logic                  gie_wdata,
    input  logic                  insn_done,
    input  logic                  sleeping,
    input  logic                  reti,
    input  logic [PC_W-1:0]       pc_in,
    input  logic [PC_W-1:0]       pop_data,
    output logic                  push_valid,
    output logic [PC_W-1:0]       push_pc,
    output logic                  pop_req,
    output logic                  pc_restore_valid,
    output logic [PC_W-1:0]       pc_restore,
    output logic                  vec_valid,
    output logic [IDX_W-1:0]      vec_idx,
    output logic [NSRC-1:0]       flags_o,
    output logic [NSRC-1:0]       enables_o,
    output logic                  gie_o
);
    sense_e           mode;
    logic             level_mode;
    logic             ext_evt;
    logic             level_req;
    logic [NSRC-1:0]  evt_all;
    logic [NSRC-1:0]  noflag;
    logic [NSRC-1:0]  hw_clr;
    logic [NSRC-1:0]  flag_q;
    logic [NSRC-1:0]  en_q;
    logic [NSRC-1:0]  pend;
    logic             req_any;
    logic [IDX_W-1:0] win_idx;
    logic             gie_q;

    assign mode       = sense_e'(sense_mode);
    assign level_mode = (mode == SENSE_LOW);

    ivc_pin_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk       (clk),
        .rst       (rst),
        .pin       (ext_pin),
        .mode      (mode),
        .edge_evt  (ext_evt),
        .level_req (level_req)
    );

    assign evt_all = {periph_evt, ext_evt};
    assign noflag  = {{NUM_PERIPH{1'b0}}, level_mode};
    assign hw_clr  = vec_valid ? (NSRC'(1) << vec_idx) : '0;

    ivc_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt_all),
        .hw_clr    (hw_clr),
        .noflag    (noflag),
        .clr_we    (clr_we),
        .clr_wdata (clr_wdata),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .flag_q    (flag_q),
        .en_q      (en_q)
    );

    always_comb begin
        pend    = flag_q & en_q;
        pend[0] = en_q[0] & (level_mode ? level_req : flag_q[0]);
    end

    ivc_prio_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
        .pend (pend),
        .any  (req_any),
        .idx  (win_idx)
    );

    ivc_sequencer #(
        .IDX_W     (IDX_W),
        .PC_W      (PC_W),
        .ENTRY_CYC (ENTRY_CYC),
        .WAKE_CYC  (WAKE_CYC),
        .RET_CYC   (RET_CYC)
    ) u_seq (
        .clk              (clk),
        .rst              (rst),
        .req_any          (req_any),
        .win_idx          (win_idx),
        .gie_we           (gie_we),
        .gie_wdata        (gie_wdata),
        .insn_done        (insn_done),
        .sleeping         (sleeping),
        .reti             (reti),
        .pc_in            (pc_in),
        .pop_data         (pop_data),
        .gie_q            (gie_q),
        .push_valid       (push_valid),
        .push_pc          (push_pc),
        .pop_req          (pop_req),
        .pc_restore_valid (pc_restore_valid),
        .pc_restore       (pc_restore),
        .vec_valid        (vec_valid),
        .vec_idx          (vec_idx)
    );

    assign flags_o   = flag_q;
    assign enables_o = en_q;
    assign gie_o     = gie_q;

    // R6: the served flag is gone one edge after the vector strobe
    a_r6_served_cleared: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !evt_all[vec_idx]) |=> !flag_q[$past(vec_idx)]);
    // R12: in low-level mode source 0 never holds a flag
    a_r12_no_level_flag: assert property (@(posedge clk) disable iff (rst)
        level_mode |=> (!flag_q[0] || !level_mode));

endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] periph_evt = '0;
    logic       ext_pin = 1'b1;
    logic [1:0] sense_mode = 2'b11;
    logic       en_we = 1'b0;
    logic [3:0] en_wdata = '0;
    logic       clr_we = 1'b0;
    logic [3:0] clr_wdata = '0;
    logic       gie_we = 1'b0;
    logic       gie_wdata = 1'b0;
    logic       insn_done = 1'b0;
    logic       sleeping = 1'b0;
    logic       reti = 1'b0;
    logic [8:0] pc_in = 9'h1A5;
    logic [8:0] pop_data = 9'h0C3;
    logic       push_valid, pop_req, pc_restore_valid, vec_valid, gie_o;
    logic [8:0] push_pc, pc_restore;
    logic [1:0] vec_idx;
    logic [3:0] flags_o, enables_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst(rst), .periph_evt(periph_evt), .ext_pin(ext_pin),
        .sense_mode(sense_mode), .en_we(en_we), .en_wdata(en_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata), .gie_we(gie_we),
        .gie_wdata(gie_wdata), .insn_done(insn_done), .sleeping(sleeping),
        .reti(reti), .pc_in(pc_in), .pop_data(pop_data),
        .push_valid(push_valid), .push_pc(push_pc), .pop_req(pop_req),
        .pc_restore_valid(pc_restore_valid), .pc_restore(pc_restore),
        .vec_valid(vec_valid), .vec_idx(vec_idx), .flags_o(flags_o),
        .enables_o(enables_o), .gie_o(gie_o)
    );

    // {periph events[9:7], enables[6:3], expect entry[2], expect index[1:0]}
    localparam logic [9:0] VECS [6] = '{
        {3'b111, 4'b1110, 1'b1, 2'd1},
        {3'b110, 4'b1110, 1'b1, 2'd2},
        {3'b100, 4'b1110, 1'b1, 2'd3},
        {3'b111, 4'b1000, 1'b1, 2'd3},
        {3'b011, 4'b1000, 1'b0, 2'd0},
        {3'b101, 4'b1010, 1'b1, 2'd1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    task automatic pulse_insn();
        insn_done = 1'b1;
        step(1);
        insn_done = 1'b0;
    endtask

    task automatic raise(input logic [2:0] ev);
        periph_evt = ev;
        step(1);
        periph_evt = '0;
    endtask

    task automatic write_en(input logic [3:0] v);
        en_we = 1'b1; en_wdata = v;
        step(1);
        en_we = 1'b0;
    endtask

    task automatic write_gie(input logic v);
        gie_we = 1'b1; gie_wdata = v;
        step(1);
        gie_we = 1'b0;
    endtask

    task automatic write_clr(input logic [3:0] v);
        clr_we = 1'b1; clr_wdata = v;
        step(1);
        clr_we = 1'b0;
    endtask

    // Serve one request at a boundary, checking push, vector and flag clear
    task automatic serve(input logic [1:0] exp);
        pulse_insn();
        check(push_valid == 1'b1, "R7 push after accept", push_valid, 1);
        step(3);
        check(vec_valid && vec_idx == exp, "R4 vector index", vec_idx, exp);
        step(1);
        check(flags_o[exp] == 1'b0, "R6 served flag cleared", flags_o, 0);
    endtask

    // Return sequence followed by the one forced instruction boundary
    task automatic do_return();
        reti = 1'b1;
        step(1);
        reti = 1'b0;
        step(3);
        step(1);
        pulse_insn();
        check(push_valid == 1'b0, "R10 no entry at first boundary", push_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        check(flags_o == 4'h0 && enables_o == 4'h0 && gie_o == 1'b0, "R1 registers",
              {flags_o, enables_o, gie_o}, 0);
        check(!push_valid && !pop_req && !pc_restore_valid && !vec_valid, "R1 strobes",
              {push_valid, pop_req, pc_restore_valid, vec_valid}, 0);

        // Vector table: priority among enabled peripheral flags
        foreach (VECS[k]) begin
            do_reset();
            raise(VECS[k][9:7]);
            check(flags_o == {VECS[k][9:7], 1'b0}, "R2 flags latched with enables off",
                  flags_o, {VECS[k][9:7], 1'b0});
            write_en(VECS[k][6:3]);
            write_gie(1'b1);
            if (VECS[k][2]) begin
                serve(VECS[k][1:0]);
                check(gie_o == 1'b0, "R5 gie cleared on accept", gie_o, 0);
            end else begin
                pulse_insn();
                check(push_valid == 1'b0, "R4 nothing pending enabled", push_valid, 0);
            end
        end

        // R3: write-one-to-clear, zero keeps, event beats clear
        do_reset();
        raise(3'b111);
        write_clr(4'b0100);
        check(flags_o == 4'b1010, "R3 one clears zero keeps", flags_o, 4'b1010);
        clr_we = 1'b1; clr_wdata = 4'b0010; periph_evt = 3'b001;
        step(1);
        clr_we = 1'b0; periph_evt = '0;
        check(flags_o == 4'b1010, "R3 event wins over clear", flags_o, 4'b1010);

        // R5 / R4 / R9 / R10: nested order, pc values, return timing
        do_reset();
        raise(3'b111);
        write_en(4'b1110);
        write_gie(1'b1);
        pc_in = 9'h1A5;
        insn_done = 1'b1;
        step(1);
        insn_done = 1'b0;
        check(push_valid && push_pc == 9'h1A5, "R7 pushed pc", push_pc, 9'h1A5);
        step(1);
        check(vec_valid == 1'b0, "R7 no early vector", vec_valid, 0);
        step(2);
        check(vec_valid && vec_idx == 2'd1, "R7 vector in 4th cycle", vec_idx, 1);
        step(1);
        check(vec_valid == 1'b0, "R7 vector one cycle", vec_valid, 0);
        pulse_insn();
        check(push_valid == 1'b0, "R5 blocked while gie off", push_valid, 0);
        pop_data = 9'h0C3;
        reti = 1'b1;
        step(1);
        reti = 1'b0;
        check(pop_req == 1'b1, "R9 pop in first cycle", pop_req, 1);
        step(2);
        check(pc_restore_valid == 1'b0 && gie_o == 1'b0, "R9 not yet done",
              {pc_restore_valid, gie_o}, 0);
        step(1);
        check(pc_restore_valid && pc_restore == 9'h0C3, "R9 restore in 4th cycle",
              pc_restore, 9'h0C3);
        step(1);
        check(gie_o == 1'b1, "R9 gie set after return", gie_o, 1);
        pulse_insn();
        check(push_valid == 1'b0, "R10 first boundary consumed", push_valid, 0);
        serve(2'd2);
        do_return();
        serve(2'd3);

        // R8: no accept without a boundary while awake
        do_reset();
        raise(3'b001);
        write_en(4'b0010);
        write_gie(1'b1);
        for (int c = 0; c < 5; c++) begin
            check(push_valid == 1'b0, "R8 waits for boundary", push_valid, 0);
            step(1);
        end
        serve(2'd1);

        // R7: waking from sleep lengthens entry
        do_reset();
        raise(3'b010);
        write_en(4'b0100);
        gie_we = 1'b1; gie_wdata = 1'b1; sleeping = 1'b1;
        step(1);
        gie_we = 1'b0;
        step(1);
        check(push_valid == 1'b1, "R7 accept while asleep", push_valid, 1);
        sleeping = 1'b0;
        step(3);
        check(vec_valid == 1'b0, "R7 sleep entry not at 4", vec_valid, 0);
        step(4);
        check(vec_valid && vec_idx == 2'd2, "R7 sleep entry at 8", vec_idx, 2);

        // R11: edge sense modes, flag on 3rd edge after pin change
        do_reset();
        sense_mode = 2'b11;
        ext_pin = 1'b0;
        step(3);
        check(flags_o[0] == 1'b0, "R11 rising ignores fall", flags_o, 0);
        ext_pin = 1'b1;
        step(2);
        check(flags_o[0] == 1'b0, "R11 not before 3rd edge", flags_o, 0);
        step(1);
        check(flags_o[0] == 1'b1, "R11 rising sets flag", flags_o, 1);
        write_clr(4'b0001);
        sense_mode = 2'b10;
        ext_pin = 1'b0;
        step(3);
        check(flags_o[0] == 1'b1, "R11 falling sets flag", flags_o, 1);
        write_clr(4'b0001);
        ext_pin = 1'b1;
        step(3);
        check(flags_o[0] == 1'b0, "R11 falling ignores rise", flags_o, 0);
        sense_mode = 2'b01;
        ext_pin = 1'b0;
        step(3);
        check(flags_o[0] == 1'b1, "R11 any change on fall", flags_o, 1);
        write_clr(4'b0001);
        ext_pin = 1'b1;
        step(3);
        check(flags_o[0] == 1'b1, "R11 any change on rise", flags_o, 1);

        // R12: low level, flagless, forgotten after pin returns high
        do_reset();
        sense_mode = 2'b00;
        write_en(4'b0001);
        ext_pin = 1'b0;
        step(3);
        check(flags_o[0] == 1'b0, "R12 no flag in level mode", flags_o, 0);
        ext_pin = 1'b1;
        step(3);
        write_gie(1'b1);
        pulse_insn();
        check(push_valid == 1'b0, "R12 level forgotten", push_valid, 0);
        ext_pin = 1'b0;
        step(3);
        serve(2'd0);
        ext_pin = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule